// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block connects a 32-bit integer core to a word-wide data memory. It takes a decoded memory instruction, the base register value and, for writes, the source register value. It computes the byte address the instruction targets, then issues a single word-aligned memory request. That request carries per-byte write enables, and write data copied into the lanes the access touches.

On a read, the unit keeps the access width, the sign mode and the low address bits in a register for one cycle. When the memory word returns, the unit picks out the addressed byte, halfword or word and widens it to 32 bits, either with sign extension or with zero fill.

The handshake takes one cycle. Within the same cycle the unit either issues the request or raises one of two fault flags. One flag marks an access that is not aligned to its width. The other marks a width code that is not defined. In both fault cases no memory request is made.

Top module: `lsu_lane_unit`

## Requirements
- R1: For a valid instruction with opcode[6:0]=0x03 (load), the effective address is rs1 plus instr[31:20] sign-extended. `mem_addr` is that address with bits 1:0 cleared, and `mem_we` is 0.
- R2: For a valid instruction with opcode[6:0]=0x23 (store), the effective address is rs1 plus the 12-bit value {instr[31:25], instr[11:7]} sign-extended. `mem_addr` is that address with bits 1:0 cleared, and `mem_we` is 1.
- R3: With a request issued, `mem_be` is set by funct3 = instr[14:12]. For the byte widths (funct3[1:0]=0), only bit ea[1:0] is set. For the halfword widths (funct3[1:0]=1), the value is 0011 when ea[1]=0 and 1100 when ea[1]=1. For the word width (funct3=2), the value is 1111. With no request, `mem_be` is 0000.
- R4: For a store, `mem_wdata` depends on funct3. For byte writes (funct3 0) it holds rs2[7:0] in all four lanes. For halfword writes (funct3 1) it holds rs2[15:0] in both halves. For word writes (funct3 2) it equals rs2.
- R5: A load request in cycle T gives `rsp_valid`=1 in cycle T+1 only. No other cycle shows `rsp_valid`=1.
- R6: In the response cycle, `load_data` is the addressed lane(s) of `mem_rdata` from that same cycle. funct3 0 and 1 sign-extend a byte and a halfword. funct3 4 and 5 zero-extend a byte and a halfword. funct3 2 returns the whole word.
- R7: A legal halfword access with ea[0]=1, or a legal word access with ea[1:0]≠0, sets `misaligned` in the same cycle and gives `mem_req`=0.
- R8: A load with funct3 3, 6 or 7, or a store with funct3 3 to 7, sets `illegal` with `mem_req`=0 and `misaligned`=0.
- R9: When `req_valid` is 0, or the opcode is neither 0x03 nor 0x23, `mem_req`, `misaligned`, `illegal` and the following cycle's `rsp_valid` are all 0.
- R10: While reset is held and in the first cycle after it, `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Instruction in `instr` is presented this cycle |
| instr | input | 32 | Memory instruction word |
| rs1_val | input | 32 | Base register value |
| rs2_val | input | 32 | Store source register value |
| mem_req | output | 1 | Memory access issued this cycle |
| mem_we | output | 1 | Issued access is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Per-byte lane enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Memory read word, one cycle after a read request |
| rsp_valid | output | 1 | Load result valid |
| load_data | output | 32 | Extracted and extended load result |
| misaligned | output | 1 | Access not aligned to its width, no request |
| illegal | output | 1 | Undefined width code, no request |

## Verification
The assertions assume that the memory answers every read exactly one cycle after the request, and that `mem_rdata` is meaningful only in that cycle. They also assume that `req_valid` stays low during reset. The bench follows both rules. It presents one instruction, then idles `req_valid` for a cycle while it drives the read word, so requests never arrive back to back. Every funct3 code for both opcodes is swept at each of the four low-address positions. Base and offset are chosen so that the offsets are positive and negative and the sums carry through the upper address bits. The returned words are rotated so that each lane is checked with its top bit both set and clear.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam logic [6:0] OPC_LOAD  = 7'h03;
  localparam logic [6:0] OPC_STORE = 7'h23;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic      sext;
    acc_size_e size;
    logic [1:0] lane;
  } ld_ctx_t;

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANE_W = 2
) (
  input  logic              req_valid,
  input  logic [31:0]       instr,
  input  logic [ADDR_W-1:0] base,
  output logic              is_load,
  output logic              is_store,
  output acc_size_e         size,
  output logic              sext,
  output logic              legal,
  output logic              misal,
  output logic [ADDR_W-1:0] ea
);

  localparam int IMM_W = 12;

  logic [6:0]       opc;
  logic [2:0]       f3;
  logic [IMM_W-1:0] imm;
  logic             unused_rs1_field;

  assign unused_rs1_field = ^instr[19:15];

  always_comb begin
    opc      = instr[6:0];
    f3       = instr[14:12];
    is_load  = req_valid && (opc == OPC_LOAD);
    is_store = req_valid && (opc == OPC_STORE);
    imm      = is_store ? {instr[31:25], instr[11:7]} : instr[31:20];
    ea       = base + {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
    size     = acc_size_e'(f3[1:0]);
    sext     = !f3[2];
    if (is_load)       legal = (f3 != 3'd3) && (f3 != 3'd6) && (f3 != 3'd7);
    else if (is_store) legal = (f3 <= 3'd2);
    else               legal = 1'b0;
    misal = legal &&
            (((size == SZ_HALF) && ea[0]) ||
             ((size == SZ_WORD) && (ea[LANE_W-1:0] != '0)));
  end

endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                      active,
  input  acc_size_e                 size,
  input  logic [$clog2(DATA_W/8)-1:0] lane,
  input  logic [DATA_W-1:0]         src,
  output logic [DATA_W/8-1:0]       be,
  output logic [DATA_W-1:0]         wdata
);

  localparam int NB     = DATA_W / 8;
  localparam int LANE_W = $clog2(NB);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    localparam logic [LANE_W-1:0] LIDX = LANE_W'(g);
    logic hit;
    always_comb begin
      unique case (size)
        SZ_BYTE: hit = (lane == LIDX);
        SZ_HALF: hit = (lane[LANE_W-1:1] == LIDX[LANE_W-1:1]);
        SZ_WORD: hit = 1'b1;
        default: hit = 1'b0;
      endcase
      be[g] = active && hit;
      unique case (size)
        SZ_BYTE: wdata[8*g +: 8] = src[7:0];
        SZ_HALF: wdata[8*g +: 8] = src[8*(g%2) +: 8];
        default: wdata[8*g +: 8] = src[8*g +: 8];
      endcase
    end
  end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  ld_ctx_t           ctx_in,
  input  logic [DATA_W-1:0] rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] data
);

  logic              valid_q, valid_d;
  ld_ctx_t           ctx_q, ctx_d;
  logic [DATA_W-1:0] shifted;

  always_comb begin
    valid_d = capture;
    ctx_d   = ctx_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ctx_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (capture) ctx_q <= ctx_d;
    end
  end

  always_comb begin
    shifted = rdata >> {ctx_q.lane, 3'b000};
    unique case (ctx_q.size)
      SZ_BYTE: data = {{(DATA_W-8){ctx_q.sext & shifted[7]}}, shifted[7:0]};
      SZ_HALF: data = {{(DATA_W-16){ctx_q.sext & shifted[15]}}, shifted[15:0]};
      default: data = shifted;
    endcase
  end

  assign rsp_valid = valid_q;

  // R6
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !ctx_q.sext && ctx_q.size == SZ_BYTE) |-> (data[DATA_W-1:8] == '0));

  // R6
  half_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && ctx_q.sext && ctx_q.size == SZ_HALF) |->
      (data[DATA_W-1:16] == {(DATA_W-16){data[15]}}));

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [31:0]         instr,
  input  logic [ADDR_W-1:0]   rs1_val,
  input  logic [DATA_W-1:0]   rs2_val,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   load_data,
  output logic                misaligned,
  output logic                illegal
);

  localparam int NB     = DATA_W / 8;
  localparam int LANE_W = $clog2(NB);

  logic              is_load, is_store, legal, misal, sext, issue;
  acc_size_e         size;
  logic [ADDR_W-1:0] ea;
  ld_ctx_t           ctx;

  lsu_addr_gen #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_addr (
    .req_valid (req_valid),
    .instr     (instr),
    .base      (rs1_val),
    .is_load   (is_load),
    .is_store  (is_store),
    .size      (size),
    .sext      (sext),
    .legal     (legal),
    .misal     (misal),
    .ea        (ea)
  );

  always_comb begin
    issue      = legal && !misal;
    mem_req    = issue;
    mem_we     = issue && is_store;
    misaligned = misal;
    illegal    = (is_load || is_store) && !legal;
    mem_addr   = {ea[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
    ctx.sext   = sext;
    ctx.size   = size;
    ctx.lane   = ea[1:0];
  end

  lsu_store_steer #(.DATA_W(DATA_W)) u_steer (
    .active (issue),
    .size   (size),
    .lane   (ea[LANE_W-1:0]),
    .src    (rs2_val),
    .be     (mem_be),
    .wdata  (mem_wdata)
  );

  lsu_load_extract #(.DATA_W(DATA_W)) u_extract (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (issue && is_load),
    .ctx_in    (ctx),
    .rdata     (mem_rdata),
    .rsp_valid (rsp_valid),
    .data      (load_data)
  );

  // R7
  misal_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |-> !mem_req);

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, misaligned, illegal}));

  // R3
  be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                 $countones(mem_be) == 4));

  // R5
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> rsp_valid);

  // R5
  rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_req && !mem_we));

endmodule

// File: tb/lsu_lane_unit_bench.sv
module lsu_lane_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, req_valid;
  logic [31:0] instr, rs1_val, rs2_val, mem_rdata;
  logic        mem_req, mem_we, rsp_valid, misaligned, illegal;
  logic [31:0] mem_addr, mem_wdata, load_data;
  logic [3:0]  mem_be;
  int          n_chk = 0;
  int          n_fail = 0;

  lsu_lane_unit u_lsu_lane_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .instr(instr),
    .rs1_val(rs1_val), .rs2_val(rs2_val), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .load_data(load_data),
    .misaligned(misaligned), .illegal(illegal)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic v, input logic [31:0] ins, input logic [31:0] base,
                        input logic [31:0] src, input logic [31:0] rword);
    logic [6:0]  opc;
    logic [2:0]  f3;
    logic        ld, st, lgl, mis, req;
    logic [11:0] imm;
    logic [31:0] ea, exp_wd, exp_ld, sh;
    logic [3:0]  exp_be;
    opc = ins[6:0];
    f3  = ins[14:12];
    ld  = v && opc == 7'h03;
    st  = v && opc == 7'h23;
    imm = st ? {ins[31:25], ins[11:7]} : ins[31:20];
    ea  = base + {{20{imm[11]}}, imm};
    lgl = (ld && (f3 == 0 || f3 == 1 || f3 == 2 || f3 == 4 || f3 == 5)) || (st && f3 <= 2);
    mis = lgl && ((f3[1:0] == 1 && ea[0]) || (f3[1:0] == 2 && ea[1:0] != 0));
    req = lgl && !mis;
    exp_be = 4'b0000;
    if (req) begin
      if (f3[1:0] == 0)      exp_be = 4'b0001 << ea[1:0];
      else if (f3[1:0] == 1) exp_be = ea[1] ? 4'b1100 : 4'b0011;
      else                   exp_be = 4'b1111;
    end
    if (f3[1:0] == 0)      exp_wd = {4{src[7:0]}};
    else if (f3[1:0] == 1) exp_wd = {2{src[15:0]}};
    else                   exp_wd = src;
    sh = rword >> (8 * ea[1:0]);
    if (f3[1:0] == 0)      exp_ld = f3[2] ? {24'd0, sh[7:0]}  : {{24{sh[7]}}, sh[7:0]};
    else if (f3[1:0] == 1) exp_ld = f3[2] ? {16'd0, sh[15:0]} : {{16{sh[15]}}, sh[15:0]};
    else                   exp_ld = rword;

    @(negedge clk);
    req_valid = v; instr = ins; rs1_val = base; rs2_val = src; mem_rdata = 32'hDEAD_0BAD;
    #1;
    if (!(ld || st)) begin
      chk("R9 mem_req", {31'd0, mem_req}, 0);
      chk("R9 flags", {30'd0, misaligned, illegal}, 0);
    end else begin
      chk(!lgl ? "R8 mem_req" : mis ? "R7 mem_req" : "R1/R2 mem_req", {31'd0, mem_req}, {31'd0, req});
      chk("R7 misaligned", {31'd0, misaligned}, {31'd0, mis});
      chk("R8 illegal", {31'd0, illegal}, {31'd0, !lgl});
      chk("R3 mem_be", {28'd0, mem_be}, {28'd0, exp_be});
      if (req) begin
        chk(ld ? "R1 mem_addr" : "R2 mem_addr", mem_addr, {ea[31:2], 2'b00});
        chk(ld ? "R1 mem_we" : "R2 mem_we", {31'd0, mem_we}, {31'd0, st});
        if (st) chk("R4 mem_wdata", mem_wdata, exp_wd);
      end
    end
    @(negedge clk);
    req_valid = 1'b0; mem_rdata = rword;
    #1;
    chk("R5 rsp_valid", {31'd0, rsp_valid}, {31'd0, req && ld});
    if (req && ld) chk("R6 load_data", load_data, exp_ld);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] seeds [3];
    logic [11:0] imms [3];
    int idx;
    seeds[0] = 32'h1000_0000; seeds[1] = 32'hFFFF_FF00; seeds[2] = 32'h0000_0040;
    imms[0]  = 12'h7FF;       imms[1]  = 12'h800;       imms[2]  = 12'h004;
    idx = 0;
    rst_n = 1'b0; req_valid = 1'b0; instr = '0; rs1_val = '0; rs2_val = '0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R10 rsp_valid in reset", {31'd0, rsp_valid}, 0);
    rst_n = 1'b1;
    #1;
    chk("R10 rsp_valid after reset", {31'd0, rsp_valid}, 0);

    for (int op = 0; op < 2; op++) begin
      for (int f = 0; f < 8; f++) begin
        for (int lo = 0; lo < 4; lo++) begin
          for (int s = 0; s < 3; s++) begin
            logic [31:0] base, ins, imx, rword;
            logic [63:0] pat;
            imx  = {{20{imms[s][11]}}, imms[s]};
            base = (seeds[s] & ~32'd3) | ((32'(lo) - imx) & 32'd3);
            if (op == 0) ins = {imms[s], 5'd9, 3'(f), 5'd31, 7'h03};
            else         ins = {imms[s][11:5], 5'd21, 5'd9, 3'(f), imms[s][4:0], 7'h23};
            pat   = {2{32'h9A7B_E416}};
            rword = 32'(pat >> (8 * (idx % 4)));
            run_op(1'b1, ins, base, 32'hC3D2_5A81 ^ (idx * 32'h0101_0101), rword);
            idx++;
          end
        end
      end
    end

    // R9: non-memory opcodes and an idle request line
    run_op(1'b1, {12'h004, 5'd1, 3'd0, 5'd2, 7'h13}, 32'h100, 32'h55, 32'h1234_5678);
    run_op(1'b1, {12'h000, 5'd1, 3'd2, 5'd2, 7'h33}, 32'h100, 32'h55, 32'h1234_5678);
    run_op(1'b1, {12'h010, 5'd1, 3'd0, 5'd2, 7'h67}, 32'h100, 32'h55, 32'h1234_5678);
    run_op(1'b0, {12'h000, 5'd1, 3'd2, 5'd2, 7'h03}, 32'h100, 32'h55, 32'h1234_5678);
    run_op(1'b0, {7'h00, 5'd3, 5'd1, 3'd0, 5'd0, 7'h23}, 32'h100, 32'h55, 32'h1234_5678);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule